// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the address-latch strobe and the active-low code-read strobe of a multiplexed external address/data bus. It runs on the oscillator clock. A divide-by-two stage turns that clock into internal states, so each state lasts two oscillator periods whatever the duty cycle of the incoming clock. Six states make one machine cycle of twelve oscillator periods.

Each machine cycle has two halves of six oscillator periods. In each half the latch strobe is high for the first state. When code is fetched from external memory, the read strobe goes low one oscillator period after the latch strobe falls and stays low to the end of that half. During an external data cycle the first latch pulse and both read pulses of that machine cycle are dropped. A software disable parks the latch pin at a weak high level instead of pulsing it. The disable is ignored while code runs externally, during data moves, code-table reads and emulation mode. Idle and power-down force fixed pin levels.

All control inputs are sampled once, at the last oscillator period of each machine cycle, and govern the whole of the next cycle.

Top module: `bus_strobe_gen`

## Requirements
- R1: With oscillator index k counted 0..11 from the start of a machine cycle and p = k mod 6, in run mode with no disable and no data cycle, `ale_o` is 1 exactly for p in {0,1}, giving two pulses per twelve oscillator clocks, and `ale_weak_o` is 0.
- R2: When the latched code-source flag is 1 (external code) in run mode without a data cycle, `psen_n_o` is 0 exactly for p in {3,4,5} and 1 otherwise.
- R3: When the latched code-source flag is 0 (internal code) and power-down is not latched, `psen_n_o` stays 1 for the whole machine cycle.
- R4: In a machine cycle with the data-cycle flag latched (run mode), `ale_o` is 0 for k in 0..5 and pulses normally for k in 6..7, and `psen_n_o` stays 1 throughout.
- R5: With the disable flag latched and not overridden in run mode, `ale_o` is 1 and `ale_weak_o` is 1 for the whole machine cycle.
- R6: The disable has no effect (R1/R4 timing, `ale_weak_o` 0) when any of external code, data cycle, code-table read or emulation mode is latched in the same cycle.
- R7: With idle latched and power-down not latched, `ale_o` is 1, `ale_weak_o` is 0 and `psen_n_o` is 1 for the whole machine cycle, regardless of the other flags.
- R8: With power-down latched, `ale_o` is 0, `ale_weak_o` is 0 and `psen_n_o` is 0 for the whole machine cycle; power-down takes priority over idle.
- R9: While `rst` is 1, `ale_o` is 0, `ale_weak_o` is 0 and `psen_n_o` is 1; on the first clock after release k is 0 and all latched flags are 0.
- R10: Control inputs are captured only on the clock edge that ends k = 11; changes at any other point do not affect the current machine cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| code_ext_i | input | 1 | 1 = code fetched from external memory |
| xdata_i | input | 1 | 1 = this machine cycle accesses external data memory |
| movc_i | input | 1 | 1 = a code-table read instruction is executing |
| idle_i | input | 1 | Idle mode active |
| pdown_i | input | 1 | Power-down mode active |
| emu_i | input | 1 | Emulation mode active |
| ale_dis_i | input | 1 | Software latch-strobe disable bit |
| ale_o | output | 1 | Latch strobe pin level |
| ale_weak_o | output | 1 | 1 = latch pin held only by a weak pull-up |
| psen_n_o | output | 1 | Active-low external code read strobe |

## Verification
The functions that meet in one cycle are the software disable and its overrides, and the pulse skipping of a data cycle together with the mode forcing of idle and power-down. The bench steps through all 128 combinations of the seven control inputs, one per machine cycle, changing them in mid cycle. So the disable is met with a data cycle or external code in the same cycle, and power-down with idle. Every oscillator period of every cycle is compared with a model that computes the pin levels from the index within the cycle and the flag priority, including the one-cycle lag of the sampled inputs.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

    // The internal state clock is the oscillator divided by two.
    localparam int OSC_PER_STATE = 2;

    // Flags captured once per machine cycle.
    typedef struct packed {
        logic code_ext;
        logic xdata;
        logic movc;
        logic emu;
        logic ale_dis;
        logic idle;
        logic pdown;
    } mc_ctrl_t;

    // Pin behaviour selected for the current oscillator period.
    typedef enum logic [1:0] {
        PIN_RUN,
        PIN_IDLE,
        PIN_PDOWN,
        PIN_RESET
    } pin_mode_e;

    typedef struct packed {
        logic ale;
        logic ale_weak;
        logic psen_n;
    } strobe_t;

    // Any of these conditions suspends the software latch disable.
    function automatic logic disable_overridden(mc_ctrl_t m);
        return m.code_ext | m.xdata | m.movc | m.emu;
    endfunction

endpackage

// File: rtl/sbg_clkdiv.sv
module sbg_clkdiv
    import sbg_pkg::*;
#(
    parameter int STATES_PER_MC = 6,
    parameter int IDX_W         = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] osc_idx,
    output logic             mc_last
);
    localparam int STATE_W    = $clog2(STATES_PER_MC);
    localparam int LAST_STATE = STATES_PER_MC - 1;

    logic               phase_q;
    logic [STATE_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            state_q <= '0;
        end else begin
            phase_q <= ~phase_q;
            if (phase_q) begin
                if (state_q == STATE_W'(LAST_STATE))
                    state_q <= '0;
                else
                    state_q <= state_q + 1'b1;
            end
        end
    end

    // Index within the machine cycle: state * 2 + phase.
    assign osc_idx = IDX_W'({state_q, phase_q});
    assign mc_last = phase_q && (state_q == STATE_W'(LAST_STATE));

endmodule

// File: rtl/sbg_mode_latch.sv
module sbg_mode_latch
    import sbg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     mc_last,
    input  mc_ctrl_t mc_d,
    output mc_ctrl_t mc_q
);
    always_ff @(posedge clk) begin
        if (rst)
            mc_q <= '0;
        else if (mc_last)
            mc_q <= mc_d;
    end

endmodule

// File: rtl/sbg_strobe_decode.sv
module sbg_strobe_decode
    import sbg_pkg::*;
#(
    parameter int OSC_PER_HALF = 6,
    parameter int IDX_W        = 4
) (
    input  logic             rst,
    input  logic [IDX_W-1:0] osc_idx,
    input  mc_ctrl_t         mc,
    output strobe_t          pins
);
    pin_mode_e        mode;
    logic             first_half;
    logic [IDX_W-1:0] pos;
    logic             ale_win;
    logic             psen_win;
    logic             dis_eff;

    always_comb begin
        if (rst)
            mode = PIN_RESET;
        else if (mc.pdown)
            mode = PIN_PDOWN;
        else if (mc.idle)
            mode = PIN_IDLE;
        else
            mode = PIN_RUN;
    end

    always_comb begin
        first_half = osc_idx < IDX_W'(OSC_PER_HALF);
        pos        = first_half ? osc_idx : osc_idx - IDX_W'(OSC_PER_HALF);
        ale_win    = pos < IDX_W'(OSC_PER_STATE);
        psen_win   = pos > IDX_W'(OSC_PER_STATE);
        dis_eff    = mc.ale_dis && !disable_overridden(mc);
    end

    always_comb begin
        pins = '{ale: 1'b0, ale_weak: 1'b0, psen_n: 1'b1};
        unique case (mode)
            PIN_RESET: pins = '{ale: 1'b0, ale_weak: 1'b0, psen_n: 1'b1};
            PIN_PDOWN: pins = '{ale: 1'b0, ale_weak: 1'b0, psen_n: 1'b0};
            PIN_IDLE:  pins = '{ale: 1'b1, ale_weak: 1'b0, psen_n: 1'b1};
            PIN_RUN: begin
                if (dis_eff) begin
                    pins.ale      = 1'b1;
                    pins.ale_weak = 1'b1;
                end else begin
                    pins.ale = ale_win && !(mc.xdata && first_half);
                end
                pins.psen_n = !(mc.code_ext && !mc.xdata && psen_win);
            end
            default: pins = '{ale: 1'b0, ale_weak: 1'b0, psen_n: 1'b1};
        endcase
    end

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import sbg_pkg::*;
#(
    parameter int STATES_PER_MC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic code_ext_i,
    input  logic xdata_i,
    input  logic movc_i,
    input  logic idle_i,
    input  logic pdown_i,
    input  logic emu_i,
    input  logic ale_dis_i,
    output logic ale_o,
    output logic ale_weak_o,
    output logic psen_n_o
);
    localparam int OSC_PER_MC   = STATES_PER_MC * OSC_PER_STATE;
    localparam int OSC_PER_HALF = OSC_PER_MC / 2;
    localparam int IDX_W        = $clog2(OSC_PER_MC);

    logic [IDX_W-1:0] osc_idx;
    logic             mc_last;
    mc_ctrl_t         mc_d;
    mc_ctrl_t         mc_q;
    strobe_t          pins;

    assign mc_d = '{code_ext: code_ext_i, xdata: xdata_i, movc: movc_i,
                    emu: emu_i, ale_dis: ale_dis_i, idle: idle_i,
                    pdown: pdown_i};

    sbg_clkdiv #(
        .STATES_PER_MC(STATES_PER_MC),
        .IDX_W        (IDX_W)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .osc_idx(osc_idx),
        .mc_last(mc_last)
    );

    sbg_mode_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .mc_last(mc_last),
        .mc_d   (mc_d),
        .mc_q   (mc_q)
    );

    sbg_strobe_decode #(
        .OSC_PER_HALF(OSC_PER_HALF),
        .IDX_W       (IDX_W)
    ) u_dec (
        .rst    (rst),
        .osc_idx(osc_idx),
        .mc     (mc_q),
        .pins   (pins)
    );

    assign ale_o      = pins.ale;
    assign ale_weak_o = pins.ale_weak;
    assign psen_n_o   = pins.psen_n;

endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk
    import sbg_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int LAST_IDX = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             ale_o,
    input logic             ale_weak_o,
    input logic             psen_n_o,
    input logic [IDX_W-1:0] osc_idx,
    input mc_ctrl_t         mc
);
    // R1: a strong latch pulse lasts two oscillator periods
    p_ale_width_r1: assert property (@(posedge clk) disable iff (rst)
        ($rose(ale_o) && !ale_weak_o) |=> ale_o);

    // R1: machine cycle index wraps after its last period
    p_idx_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (osc_idx == IDX_W'(LAST_IDX)) |=> (osc_idx == '0));

    // R3: no code read strobe while executing internally
    p_psen_internal_r3: assert property (@(posedge clk) disable iff (rst)
        (!mc.code_ext && !mc.pdown) |-> psen_n_o);

    // R4: no code read strobe during a data cycle
    p_xdata_psen_r4: assert property (@(posedge clk) disable iff (rst)
        (mc.xdata && !mc.pdown) |-> psen_n_o);

    // R5: a weakly held pin is always high
    p_weak_high_r5: assert property (@(posedge clk) disable iff (rst)
        ale_weak_o |-> ale_o);

    // R8: power-down pins low
    p_pdown_pins_r8: assert property (@(posedge clk) disable iff (rst)
        mc.pdown |-> (!ale_o && !psen_n_o && !ale_weak_o));

    // R10: captured flags only change at the start of a machine cycle
    p_flags_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (osc_idx != '0) |-> $stable(mc));

endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(
    .IDX_W   (IDX_W),
    .LAST_IDX(OSC_PER_MC - 1)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ale_o     (ale_o),
    .ale_weak_o(ale_weak_o),
    .psen_n_o  (psen_n_o),
    .osc_idx   (osc_idx),
    .mc        (mc_q)
);

// File: tb/bus_strobe_gen_tb.sv
`timescale 1ns/1ps
module bus_strobe_gen_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic code_ext_i = 1'b0, xdata_i = 1'b0, movc_i = 1'b0, idle_i = 1'b0;
    logic pdown_i = 1'b0, emu_i = 1'b0, ale_dis_i = 1'b0;
    logic ale_o, ale_weak_o, psen_n_o;

    int checks = 0;
    int errors = 0;
    bit checking = 1'b0;
    bit finished = 1'b0;
    string tag_ovr = "";

    // bench model: index within machine cycle and captured control vector
    // bit order: 0 code_ext, 1 xdata, 2 movc, 3 emu, 4 ale_dis, 5 idle, 6 pdown
    int k = 0;
    logic [6:0] mf = '0;

    always #10 clk = ~clk;

    bus_strobe_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .code_ext_i(code_ext_i),
        .xdata_i   (xdata_i),
        .movc_i    (movc_i),
        .idle_i    (idle_i),
        .pdown_i   (pdown_i),
        .emu_i     (emu_i),
        .ale_dis_i (ale_dis_i),
        .ale_o     (ale_o),
        .ale_weak_o(ale_weak_o),
        .psen_n_o  (psen_n_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            k  <= 0;
            mf <= '0;
        end else begin
            if (k == 11)
                mf <= {pdown_i, idle_i, ale_dis_i, emu_i, movc_i, xdata_i, code_ext_i};
            k <= (k == 11) ? 0 : k + 1;
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            logic e_ale, e_weak, e_psen, dis, ovr;
            int p;
            string tag;
            p   = k % 6;
            ovr = mf[0] | mf[1] | mf[2] | mf[3];
            dis = mf[4] && !ovr;
            if (rst) begin
                e_ale = 0; e_weak = 0; e_psen = 1; tag = "R9";
            end else if (mf[6]) begin
                e_ale = 0; e_weak = 0; e_psen = 0; tag = "R8";
            end else if (mf[5]) begin
                e_ale = 1; e_weak = 0; e_psen = 1; tag = "R7";
            end else begin
                if (dis) begin
                    e_ale = 1; e_weak = 1; tag = "R5";
                end else begin
                    e_ale = (p < 2) && !(mf[1] && k < 6); e_weak = 0;
                    if (mf[4]) tag = "R6";
                    else if (mf[1]) tag = "R4";
                    else if (mf[0]) tag = "R2";
                    else tag = "R1";
                end
                e_psen = !(mf[0] && !mf[1] && p >= 3);
                if (!mf[0] && tag == "R1") tag = "R3";
            end
            if (tag_ovr != "") tag = tag_ovr;
            checks++;
            if (ale_o !== e_ale || ale_weak_o !== e_weak || psen_n_o !== e_psen) begin
                errors++;
                $display("FAIL %s k=%0d flags=%b: ale/weak/psen_n actual %b%b%b expected %b%b%b",
                         tag, k, mf, ale_o, ale_weak_o, psen_n_o, e_ale, e_weak, e_psen);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_k(input int target);
        step();
        while (k != target) step();
    endtask

    task automatic drive(input logic [6:0] v);
        {pdown_i, idle_i, ale_dis_i, emu_i, movc_i, xdata_i, code_ext_i} = v;
    endtask

    initial begin
        checking = 1'b1;
        // R9: reset state
        repeat (4) step();
        rst = 1'b0;
        // full sweep, inputs changed mid cycle (R10 lag covered by model)
        for (int c = 0; c < 128; c++) begin
            wait_k(3);
            drive(7'(c));
        end
        wait_k(3);
        drive('0);
        repeat (2) wait_k(3);
        // R10: power-down raised late in a run cycle must not touch it
        drive(7'b0000001);
        wait_k(10);
        tag_ovr = "R10";
        drive(7'b1000001);
        wait_k(11);
        drive(7'b0000001);
        wait_k(5);
        tag_ovr = "";
        // R9: reset in mid cycle, then restart from k = 0 with cleared flags
        drive(7'b0010011);
        wait_k(7);
        rst = 1'b1;
        tag_ovr = "R9";
        repeat (3) step();
        rst = 1'b0;
        repeat (12) step();
        tag_ovr = "";
        repeat (24) step();
        checking = 1'b0;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule